// File: doc/BRIEF.md
# Per-Line Input Glitch and Debounce Filter Bank

This block conditions a bank of general-purpose input lines before their levels are offered to software. Each raw line is first brought into the master clock domain by a two-stage synchronizer. It then passes through a small per-line filter that can be switched off, in which case the synchronized level passes straight through.

When the filter for a line is on, it runs in one of two modes:

- **Fast mode** samples on every master clock cycle and rejects single-cycle glitches.
- **Slow mode** samples at ticks from one shared divider that runs on a slow reference tick, which debounces mechanical contacts.

Both modes share one rule. The published level changes only after two consecutive samples agree on a value that differs from the current level. A pulse shorter than half a sample-clock period is therefore always dropped, and a pulse lasting a full period or longer always gets through.

Software reaches the block through a flat register port with eight addresses. A write strobe carries address and data. A read address selects a combinational read-back word.

The filter-enable bits and the mode bits are each changed through a write-only set address and a write-only clear address. Each also has a readable status address. The divider value has its own address. The filtered levels of all lines are read at the last address.

A clock-run input stands for the controller's clock enable. While it is low, all line state freezes, so the pin status keeps the levels captured when the clock stopped. The slow reference arrives as a one-cycle tick in the master clock domain, so all state lives in one clock domain.

Each line filter is a two-state machine:

- **LINE_SETTLED**: the output equals the last accepted level.
- **LINE_CANDIDATE**: one sample has disagreed with the output.

Its transitions are:

- **SETTLED→CANDIDATE** when a sample differs from the output.
- **CANDIDATE→SETTLED with update** when the next sample also differs; the output takes the new level.
- **CANDIDATE→SETTLED without update** when the next sample agrees with the current output.
- **Bypass**: when the filter is off, the machine is forced to SETTLED and the output follows the synchronizer.

Top module: `pin_filter_bank`

## Requirements
- R1: After reset every filter is off, every line is in fast mode, the divider value is 0 and the pin status word reads 0.
- R2: Writing address 0 turns on the filter of each line whose data bit is 1. Writing address 1 turns it off for each such line. Lines whose data bit is 0 keep their setting. Address 2 reads the enable bits (1 = on). A change is visible right after the clock edge that accepts the write.
- R3: Writing address 3 sets mode bits and writing address 4 clears them, with the same bitwise rule as R2. Address 5 reads the mode bits: 0 = fast mode on the master clock, 1 = slow mode on the divided tick.
- R4: Address 6 holds the divider value DIV in its low DIV_W bits (read/write). The slow-mode sample tick fires on every (DIV+1)-th slow reference tick, which is half a divided-clock period of 2*(DIV+1) reference periods, and only ever in a cycle that carries a reference tick.
- R5: With its filter off, a line's new level shows in the pin status word (address 7) starting on the third master clock edge after the change, and not before.
- R6: In fast mode a level is accepted only when seen on two consecutive master clock samples. A one-cycle pulse never reaches the status word, a pulse of two or more cycles always does, and a change shows starting on the fourth edge.
- R7: In slow mode the line is sampled only at divided sample ticks and changes only when two consecutive tick samples agree. A pulse shorter than half a divided period is always rejected, and a pulse of one full divided period or more is always passed.
- R8: The pin status word reports the current level of every line at once, whatever the other lines' configuration.
- R9: While the clock-run input is low, the pin status word, the synchronizer, the filters and the divider hold their values. After the input returns high, pending pin changes proceed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_run | input | 1 | Controller clock enable; low freezes line state |
| slow_tick | input | 1 | One-cycle slow reference tick, master clock domain |
| pin_in | input | NPINS | Raw asynchronous input lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | NPINS | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | NPINS | Combinational read-back word |

## Verification
The bench sends pulses of one and two cycles in fast mode. A filter that accepts on a single sample would let the one-cycle pulse through, and one that needs three samples would swallow the two-cycle pulse.

In slow mode it sends pulses just under and well over the divided half-period. A divider that is off by one, or sampling on the master clock instead of the tick, lets the short pulses leak through.

It counts the exact edge on which bypass and fast-mode changes appear, so a missing or extra register stage shows up. It writes zero words to the set and clear addresses and expects no change. It also stops the clock-run input to confirm the status word stays frozen until the clock returns.

// File: rtl/pin_filter_pkg.sv
package pin_filter_pkg;

    typedef enum logic [2:0] {
        ADDR_FILT_ON   = 3'd0,
        ADDR_FILT_OFF  = 3'd1,
        ADDR_FILT_STAT = 3'd2,
        ADDR_SLOW_SET  = 3'd3,
        ADDR_SLOW_CLR  = 3'd4,
        ADDR_SLOW_STAT = 3'd5,
        ADDR_DIV       = 3'd6,
        ADDR_PIN_STAT  = 3'd7
    } reg_addr_e;

    typedef enum logic {
        LINE_SETTLED   = 1'b0,
        LINE_CANDIDATE = 1'b1
    } line_state_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [NPINS-1:0] din,
    output logic [NPINS-1:0] dout
);
    logic [NPINS-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (run) begin
                    if (s == 0) stage_q[s] <= din;
                    else        stage_q[s] <= stage_q[(s > 0) ? s-1 : 0];
                end
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/slow_divider.sv
module slow_divider #(
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             slow_tick,
    input  logic [DIV_W-1:0] div,
    output logic             half_tick
);
    logic [DIV_W-1:0] cnt_q;

    assign half_tick = run && slow_tick && (cnt_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (run && slow_tick) begin
            cnt_q <= half_tick ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/line_filter.sv
module line_filter
    import pin_filter_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic filt_on,
    input  logic slow_mode,
    input  logic half_tick,
    input  logic din,
    output logic dout
);
    line_state_e state_q, state_d;
    logic        out_q, out_d;
    logic        sample_now;

    assign sample_now = slow_mode ? half_tick : 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LINE_SETTLED;
            out_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            out_q   <= out_d;
        end
    end

    always_comb begin
        state_d = state_q;
        out_d   = out_q;
        if (!run) begin
            state_d = state_q;
        end else if (!filt_on) begin
            state_d = LINE_SETTLED;
            out_d   = din;
        end else if (sample_now) begin
            unique case (state_q)
                LINE_SETTLED: begin
                    if (din != out_q) state_d = LINE_CANDIDATE;
                end
                LINE_CANDIDATE: begin
                    if (din != out_q) out_d = din;
                    state_d = LINE_SETTLED;
                end
                default: state_d = LINE_SETTLED;
            endcase
        end
    end

    assign dout = out_q;
endmodule

// File: rtl/filter_regs.sv
module filter_regs
    import pin_filter_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [NPINS-1:0] wr_data,
    output logic [NPINS-1:0] filt_en,
    output logic [NPINS-1:0] slow_sel,
    output logic [DIV_W-1:0] div
);
    reg_addr_e addr;
    assign addr = reg_addr_e'(wr_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filt_en  <= '0;
            slow_sel <= '0;
            div      <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_FILT_ON:  filt_en  <= filt_en | wr_data;
                ADDR_FILT_OFF: filt_en  <= filt_en & ~wr_data;
                ADDR_SLOW_SET: slow_sel <= slow_sel | wr_data;
                ADDR_SLOW_CLR: slow_sel <= slow_sel & ~wr_data;
                ADDR_DIV:      div      <= wr_data[DIV_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pin_filter_bank.sv
module pin_filter_bank
    import pin_filter_pkg::*;
#(
    parameter int NPINS = 32,
    parameter int DIV_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_run,
    input  logic             slow_tick,
    input  logic [NPINS-1:0] pin_in,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [NPINS-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [NPINS-1:0] rd_data
);
    localparam int PAD_W = NPINS - DIV_W;

    logic [NPINS-1:0] sync_q;
    logic [NPINS-1:0] filt_en;
    logic [NPINS-1:0] slow_sel;
    logic [DIV_W-1:0] div;
    logic             half_tick;
    logic [NPINS-1:0] pin_level;

    pin_sync #(.NPINS(NPINS), .STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .run(clk_run), .din(pin_in), .dout(sync_q)
    );

    filter_regs #(.NPINS(NPINS), .DIV_W(DIV_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .filt_en(filt_en), .slow_sel(slow_sel), .div(div)
    );

    slow_divider #(.DIV_W(DIV_W)) div_i (
        .clk(clk), .rst_n(rst_n), .run(clk_run), .slow_tick(slow_tick),
        .div(div), .half_tick(half_tick)
    );

    genvar i;
    generate
        for (i = 0; i < NPINS; i++) begin : g_line
            line_filter line_i (
                .clk(clk), .rst_n(rst_n), .run(clk_run),
                .filt_on(filt_en[i]), .slow_mode(slow_sel[i]),
                .half_tick(half_tick), .din(sync_q[i]), .dout(pin_level[i])
            );
        end
    endgenerate

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            ADDR_FILT_STAT: rd_data = filt_en;
            ADDR_SLOW_STAT: rd_data = slow_sel;
            ADDR_DIV:       rd_data = {{PAD_W{1'b0}}, div};
            ADDR_PIN_STAT:  rd_data = pin_level;
            default:        rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pin_filter_bank_chk.sv
module pin_filter_bank_chk #(
    parameter int NPINS = 32,
    parameter int DIV_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clk_run,
    input logic             slow_tick,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [NPINS-1:0] wr_data,
    input logic [NPINS-1:0] sync_q,
    input logic [NPINS-1:0] filt_en,
    input logic [NPINS-1:0] slow_sel,
    input logic             half_tick,
    input logic [NPINS-1:0] pin_level
);
    // R2
    filt_on_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> filt_en == ($past(filt_en) | $past(wr_data)));

    // R4
    half_tick_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        half_tick |-> (slow_tick && clk_run));

    // R5
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_run |=> ((pin_level ^ $past(sync_q)) & ~$past(filt_en)) == '0);

    // R6
    fast_two_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_run |=> ((pin_level ^ $past(pin_level)) & $past(filt_en & ~slow_sel)
                     & ((pin_level ^ $past(sync_q)) | (pin_level ^ $past(sync_q, 2)))) == '0);

    // R7
    slow_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (((pin_level ^ $past(pin_level)) & $past(filt_en & slow_sel)) != '0) |-> $past(half_tick));

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_run |=> $stable(pin_level));
endmodule

bind pin_filter_bank pin_filter_bank_chk #(.NPINS(NPINS), .DIV_W(DIV_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .clk_run(clk_run), .slow_tick(slow_tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sync_q(sync_q),
    .filt_en(filt_en), .slow_sel(slow_sel), .half_tick(half_tick),
    .pin_level(pin_level)
);

// File: tb/pin_filter_bank_tb_top.sv
module pin_filter_bank_tb_top;
    localparam int NPINS = 32;
    localparam int DIV_W = 14;
    localparam int LINE  = 5;

    typedef struct packed {
        logic [1:0] mode;   // 0 off, 1 fast, 2 slow
        logic [7:0] width;
        logic       pass;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 8'd1,  1'b1},   // R5
        '{2'd1, 8'd1,  1'b0},   // R6
        '{2'd1, 8'd2,  1'b1},   // R6
        '{2'd1, 8'd5,  1'b1},   // R6
        '{2'd2, 8'd6,  1'b0},   // R7
        '{2'd2, 8'd7,  1'b0},   // R7
        '{2'd2, 8'd16, 1'b1},   // R7
        '{2'd2, 8'd24, 1'b1}    // R7
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_run = 1'b1;
    logic             slow_tick = 1'b0;
    logic [NPINS-1:0] pin_in = '0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [NPINS-1:0] wr_data = '0;
    logic [2:0]       rd_addr = 3'd7;
    logic [NPINS-1:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    logic seen = 1'b0;
    logic watch = 1'b0;

    pin_filter_bank #(.NPINS(NPINS), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_run(clk_run), .slow_tick(slow_tick),
        .pin_in(pin_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #2 clk = ~clk;

    // slow reference: one tick every 4 master cycles
    initial begin
        int c = 0;
        forever begin
            @(negedge clk);
            slow_tick = (c % 4 == 0);
            c++;
        end
    end

    always @(negedge clk) if (watch && rd_addr == 3'd7 && rd_data[LINE]) seen = 1'b1;

    task automatic check(input string req, input logic [NPINS-1:0] act, input logic [NPINS-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [NPINS-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [NPINS-1:0] d);
        rd_addr = a;
        #0.5;
        d = rd_data;
        rd_addr = 3'd7;
        #0.5;
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [NPINS-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd2, v); check("R1 filt", v, '0);
        rd(3'd5, v); check("R1 mode", v, '0);
        rd(3'd6, v); check("R1 div", v, '0);
        rd(3'd7, v); check("R1 pin", v, '0);

        // R2 set/clear, zero bits ignored
        wr(3'd0, 32'h0000_00F0); rd(3'd2, v); check("R2 set", v, 32'h0000_00F0);
        wr(3'd0, 32'h0); rd(3'd2, v); check("R2 zero set", v, 32'h0000_00F0);
        wr(3'd1, 32'h0000_0030); rd(3'd2, v); check("R2 clr", v, 32'h0000_00C0);
        wr(3'd1, 32'h0); rd(3'd2, v); check("R2 zero clr", v, 32'h0000_00C0);
        wr(3'd1, '1);

        // R3 mode bits
        wr(3'd3, 32'h8000_0001); rd(3'd5, v); check("R3 set", v, 32'h8000_0001);
        wr(3'd4, 32'h0000_0001); rd(3'd5, v); check("R3 clr", v, 32'h8000_0000);
        wr(3'd4, '1);

        // R4 divider
        wr(3'd6, 32'h0000_0001); rd(3'd6, v); check("R4 div", v, 32'h1);

        // R8 all lines, no filter
        @(negedge clk); pin_in = 32'hA5A5_3C3C;
        repeat (4) @(negedge clk);
        rd(3'd7, v); check("R8 pattern", v, 32'hA5A5_3C3C);
        pin_in = '0; repeat (4) @(negedge clk);

        // R5 bypass latency: new value on third edge
        pin_in[LINE] = 1'b1;
        repeat (2) @(negedge clk);
        check("R5 before", rd_data[LINE], 1'b0);
        @(negedge clk);
        check("R5 third edge", rd_data[LINE], 1'b1);
        pin_in[LINE] = 1'b0; repeat (4) @(negedge clk);

        // R6 fast latency: fourth edge
        wr(3'd0, 32'h1 << LINE);
        repeat (4) @(negedge clk);
        pin_in[LINE] = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 before", rd_data[LINE], 1'b0);
        @(negedge clk);
        check("R6 fourth edge", rd_data[LINE], 1'b1);
        pin_in[LINE] = 1'b0; repeat (6) @(negedge clk);

        // R9 freeze
        clk_run = 1'b0;
        pin_in[LINE] = 1'b1;
        repeat (10) @(negedge clk);
        check("R9 frozen", rd_data[LINE], 1'b0);
        clk_run = 1'b1;
        repeat (6) @(negedge clk);
        check("R9 resumed", rd_data[LINE], 1'b1);
        pin_in[LINE] = 1'b0; repeat (8) @(negedge clk);

        // pulse-width table on LINE (R5, R6, R7, R4 with DIV=1)
        foreach (VECS[k]) begin
            if (VECS[k].mode == 2'd0) wr(3'd1, 32'h1 << LINE);
            else                      wr(3'd0, 32'h1 << LINE);
            if (VECS[k].mode == 2'd2) wr(3'd3, 32'h1 << LINE);
            else                      wr(3'd4, 32'h1 << LINE);
            repeat (40) @(negedge clk);
            seen = 1'b0; watch = 1'b1;
            pin_in[LINE] = 1'b1;
            repeat (int'(VECS[k].width)) @(negedge clk);
            pin_in[LINE] = 1'b0;
            repeat (48) @(negedge clk);
            watch = 1'b0;
            check((VECS[k].mode == 2'd2) ? "R7 R4 slow pulse" :
                  (VECS[k].mode == 2'd1) ? "R6 fast pulse" : "R5 bypass pulse",
                  {31'b0, seen}, {31'b0, VECS[k].pass});
            check("R7 R6 back low", rd_data[LINE], 1'b0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule